// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the descriptor side of a transmit DMA engine. Each descriptor is four 32-bit words in host memory. The walker reads the four words of one descriptor over a single request/acknowledge memory port. Word 0 carries control flags and an ownership bit. Word 1 carries two byte counts. Word 2 is the first buffer address. Word 3 is either the second buffer address or a link to the next descriptor.

A descriptor owned by the engine is turned into one or two segment requests on a fetch port, which a separate data mover consumes. The walker then writes word 0 back with the ownership bit cleared, which returns the descriptor to the host. After that it can pulse a completion interrupt and move on to the next descriptor.

In ring mode the next descriptor follows the current one after 16 bytes, or the walker returns to the base address when the end-of-ring flag is set. In chained mode the next address comes from word 3. When the walker reads a descriptor the host still owns, it parks and flags that no buffer is available. It reads that same descriptor again only after a poll-demand strobe.

The state machine has these states:
- IDLE: after reset.
- RD_CTRL, RD_LEN, RD_BUF1, RD_BUF2: the four word reads.
- SEG1, SEG2: the two buffer segments.
- RETURN: the write-back.
- ADVANCE: the address update and interrupt.
- SUSPEND: parked on a host-owned descriptor.

Its transitions are:
- IDLE→RD_CTRL on poll, loading the base address.
- RD_CTRL→RD_LEN on acknowledge when word 0 bit 31 is set.
- RD_CTRL→SUSPEND on acknowledge when word 0 bit 31 is clear.
- RD_LEN→RD_BUF1→RD_BUF2→SEG1, each step on acknowledge.
- SEG1→SEG2 on segment done, or at once if the segment is unused.
- SEG2→RETURN on segment done, or at once if the segment is unused.
- RETURN→ADVANCE on acknowledge.
- ADVANCE→RD_CTRL unconditionally.
- SUSPEND→RD_CTRL on poll.

Top module: `txdesc_walker`

## Requirements
- R1: After reset the block makes no memory request and no segment request, and `tx_irq` and `buf_unavail` are low. It stays quiet until `poll_demand` is pulsed. The first poll starts at `cfg_base`.
- R2: A descriptor at address A is read as four words, at A, A+4, A+8 and A+12, in that order. The walk continues only when bit 31 of the first word (ownership, 1 = engine) is set.
- R3: If bit 31 of word 0 reads as 0, no further word is read and `buf_unavail` rises. No memory or segment request follows. A `poll_demand` clears the flag and re-reads the same descriptor address.
- R4: Segment 1 presents address = word 2 and length = word 1 bits 12:0. Segment 2 presents address = word 3 and length = word 1 bits 28:16. Segment 1 comes first, and each segment is held stable until `seg_done`.
- R5: A segment whose length is zero is skipped without raising `seg_valid`.
- R6: `seg_first` copies word 0 bit 28 on the first used segment and is 0 otherwise. `seg_last` copies word 0 bit 29 on the last used segment and is 0 otherwise.
- R7: After the segments, word 0 is written back to address A with bit 31 cleared and all other bits unchanged. The walker does not advance until that write is acknowledged.
- R8: `tx_irq` pulses for one cycle, the cycle after the write-back acknowledge, exactly when word 0 bits 30 and 29 are both set.
- R9: In ring mode (`cfg_chain`=0) the next descriptor is at A+16. When word 0 bit 21 is set, the next descriptor is at `cfg_base` instead.
- R10: In chained mode (`cfg_chain`=1) the next descriptor is at the address in word 3, and bit 21 is ignored. Segment 2 is never presented.
- R11: A memory request keeps its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_chain | input | 1 | 1 = follow word 3 link, 0 = ring stepping |
| cfg_base | input | ADDR_W | Address of the first descriptor of the list |
| poll_demand | input | 1 | Start or resume strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| seg_valid | output | 1 | A segment is offered to the data mover |
| seg_addr | output | ADDR_W | Segment buffer address |
| seg_len | output | 13 | Segment byte count |
| seg_first | output | 1 | Segment starts a frame |
| seg_last | output | 1 | Segment ends a frame |
| seg_done | input | 1 | Data mover has consumed the segment |
| tx_irq | output | 1 | One-cycle completion interrupt |
| buf_unavail | output | 1 | Parked on a host-owned descriptor |

## Verification
A three-descriptor ring is used to tell the two segment paths apart. Its descriptors have both buffers used, only the second buffer used, and only the first buffer used with end-of-ring set. This shows how the first and last flags move to whichever segment is actually used, and how zero-length skipping works. The wrap then lands on a descriptor that was just returned, which separates the suspend path from a blind walk. After that descriptor is re-armed and polled, a self-wrapping descriptor without an interrupt request confirms that the walk resumes at the same address and that no interrupt is raised. A chained pair, whose second buffer count is nonzero and whose end-of-ring flag is set, shows that the link word, not stepping or wrapping, selects the next address, and that buffer 2 is suppressed. Varied memory and data-mover latencies check that requests are held across wait cycles.

// File: rtl/txdw_pkg.sv
package txdw_pkg;
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 13;
    localparam int DESC_WORDS  = 4;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int DESC_STRIDE = DESC_WORDS * WORD_BYTES;
    localparam int LEN1_LSB    = 0;
    localparam int LEN2_LSB    = 16;
    localparam int OWN_BIT     = 31;
    localparam int IRQ_BIT     = 30;
    localparam int LAST_BIT    = 29;
    localparam int FIRST_BIT   = 28;
    localparam int EOR_BIT     = 21;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_RD_LEN,
        ST_RD_BUF1,
        ST_RD_BUF2,
        ST_SEG1,
        ST_SEG2,
        ST_RETURN,
        ST_ADVANCE,
        ST_SUSPEND
    } walk_state_e;
endpackage

// File: rtl/txdw_next_addr.sv
module txdw_next_addr
    import txdw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] link_addr,
    input  logic              chain,
    input  logic              end_of_ring,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_STRIDE);

    always_comb begin
        if (chain)
            next_addr = link_addr;
        else if (end_of_ring)
            next_addr = base_addr;
        else
            next_addr = cur_addr + STEP;
    end
endmodule

// File: rtl/txdw_seg_sel.sv
module txdw_seg_sel
    import txdw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              second,
    input  logic              chain,
    input  logic [WORD_W-1:0] ctrl,
    input  logic [WORD_W-1:0] lens,
    input  logic [ADDR_W-1:0] buf1,
    input  logic [ADDR_W-1:0] buf2,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len,
    output logic              used,
    output logic              first,
    output logic              last
);
    logic [LEN_W-1:0] len1;
    logic [LEN_W-1:0] len2;
    logic             use1;
    logic             use2;

    assign len1 = lens[LEN1_LSB +: LEN_W];
    assign len2 = lens[LEN2_LSB +: LEN_W];
    assign use1 = (len1 != '0);
    assign use2 = !chain && (len2 != '0);

    always_comb begin
        if (second) begin
            addr  = buf2;
            len   = len2;
            used  = use2;
            first = ctrl[FIRST_BIT] && !use1;
            last  = ctrl[LAST_BIT];
        end else begin
            addr  = buf1;
            len   = len1;
            used  = use1;
            first = ctrl[FIRST_BIT];
            last  = ctrl[LAST_BIT] && !use2;
        end
    end
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
    import txdw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_chain,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              poll_demand,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              seg_valid,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              seg_first,
    output logic              seg_last,
    input  logic              seg_done,
    output logic              tx_irq,
    output logic              buf_unavail
);
    localparam logic [ADDR_W-1:0] OFS_LEN  = ADDR_W'(1 * WORD_BYTES);
    localparam logic [ADDR_W-1:0] OFS_BUF1 = ADDR_W'(2 * WORD_BYTES);
    localparam logic [ADDR_W-1:0] OFS_BUF2 = ADDR_W'(3 * WORD_BYTES);

    walk_state_e       state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] lens_q;
    logic [ADDR_W-1:0] buf1_q;
    logic [ADDR_W-1:0] buf2_q;
    logic              unavail_q;
    logic [ADDR_W-1:0] next_addr;
    logic              seg_used;

    txdw_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur_addr   (cur_addr),
        .base_addr  (cfg_base),
        .link_addr  (buf2_q),
        .chain      (cfg_chain),
        .end_of_ring(ctrl_q[EOR_BIT]),
        .next_addr  (next_addr)
    );

    txdw_seg_sel #(.ADDR_W(ADDR_W)) u_sel (
        .second(state == ST_SEG2),
        .chain (cfg_chain),
        .ctrl  (ctrl_q),
        .lens  (lens_q),
        .buf1  (buf1_q),
        .buf2  (buf2_q),
        .addr  (seg_addr),
        .len   (seg_len),
        .used  (seg_used),
        .first (seg_first),
        .last  (seg_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (poll_demand) state_nx = ST_RD_CTRL;
            ST_SUSPEND: if (poll_demand) state_nx = ST_RD_CTRL;
            ST_RD_CTRL: if (mem_ack) state_nx = mem_rdata[OWN_BIT] ? ST_RD_LEN : ST_SUSPEND;
            ST_RD_LEN:  if (mem_ack) state_nx = ST_RD_BUF1;
            ST_RD_BUF1: if (mem_ack) state_nx = ST_RD_BUF2;
            ST_RD_BUF2: if (mem_ack) state_nx = ST_SEG1;
            ST_SEG1:    if (!seg_used || seg_done) state_nx = ST_SEG2;
            ST_SEG2:    if (!seg_used || seg_done) state_nx = ST_RETURN;
            ST_RETURN:  if (mem_ack) state_nx = ST_ADVANCE;
            ST_ADVANCE: state_nx = ST_RD_CTRL;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Descriptor capture and walk address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            ctrl_q    <= '0;
            lens_q    <= '0;
            buf1_q    <= '0;
            buf2_q    <= '0;
            unavail_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && poll_demand) cur_addr <= cfg_base;
            if (state == ST_ADVANCE)             cur_addr <= next_addr;
            if (mem_ack) begin
                if (state == ST_RD_CTRL) ctrl_q <= mem_rdata;
                if (state == ST_RD_LEN)  lens_q <= mem_rdata;
                if (state == ST_RD_BUF1) buf1_q <= mem_rdata[ADDR_W-1:0];
                if (state == ST_RD_BUF2) buf2_q <= mem_rdata[ADDR_W-1:0];
            end
            if (state == ST_RD_CTRL && mem_ack && !mem_rdata[OWN_BIT]) unavail_q <= 1'b1;
            else if (state == ST_SUSPEND && poll_demand)               unavail_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_addr;
        mem_wdata = ctrl_q;
        mem_wdata[OWN_BIT] = 1'b0;
        seg_valid = 1'b0;
        tx_irq    = 1'b0;
        unique case (state)
            ST_RD_CTRL: mem_req = 1'b1;
            ST_RD_LEN:  begin mem_req = 1'b1; mem_addr = cur_addr + OFS_LEN;  end
            ST_RD_BUF1: begin mem_req = 1'b1; mem_addr = cur_addr + OFS_BUF1; end
            ST_RD_BUF2: begin mem_req = 1'b1; mem_addr = cur_addr + OFS_BUF2; end
            ST_SEG1, ST_SEG2: seg_valid = seg_used;
            ST_RETURN:  begin mem_req = 1'b1; mem_we = 1'b1; end
            ST_ADVANCE: tx_irq = ctrl_q[IRQ_BIT] && ctrl_q[LAST_BIT];
            ST_IDLE, ST_SUSPEND: ;
            default: ;
        endcase
    end
    assign buf_unavail = unavail_q;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    assert_wb_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[OWN_BIT]);
    assert_irq_after_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(mem_req && mem_we && mem_ack));
    assert_suspend_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_unavail |-> !mem_req && !seg_valid);
    assert_seg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !seg_done |=> seg_valid && $stable(seg_addr) && $stable(seg_len));
    assert_chain_one_seg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && cfg_chain |-> state == ST_SEG1);
endmodule

// File: tb/txdesc_walker_tb.sv
module txdesc_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_chain = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic          poll_demand = 1'b0;
    logic          mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata = '0;
    logic          seg_valid, seg_first, seg_last, seg_done = 1'b0;
    logic [AW-1:0] seg_addr;
    logic [12:0]   seg_len;
    logic          tx_irq, buf_unavail;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdesc_walker #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_chain(cfg_chain), .cfg_base(cfg_base),
        .poll_demand(poll_demand), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_first(seg_first), .seg_last(seg_last),
        .seg_done(seg_done), .tx_irq(tx_irq), .buf_unavail(buf_unavail)
    );

    typedef struct {
        int          kind;   // 1 read, 2 write, 3 segment, 4 irq
        logic [31:0] a;
        logic [31:0] d;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] mem    [0:127];
    logic [31:0] shadow [0:127];
    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.tag = tag;
        expq.push_back(e);
    endtask

    // Predict the traffic of one descriptor from the requirements (shadow memory)
    task automatic expect_desc(input logic [31:0] a, input bit chain, input logic [31:0] base,
                               input string rd_tag, output bit owned, output logic [31:0] nxt);
        logic [31:0] w0, w1, w2, w3;
        logic [12:0] l1, l2;
        bit u1, u2;
        w0 = shadow[a[8:2]]; w1 = shadow[a[8:2]+1]; w2 = shadow[a[8:2]+2]; w3 = shadow[a[8:2]+3];
        push(1, a, 0, rd_tag);
        owned = w0[31];
        nxt = a;
        if (!owned) return;
        push(1, a + 4, 0, "R2");
        push(1, a + 8, 0, "R2");
        push(1, a + 12, 0, "R2");
        l1 = w1[12:0]; l2 = w1[28:16];
        u1 = (l1 != 0); u2 = !chain && (l2 != 0);
        if (u1) push(3, w2, {17'd0, w0[28], w0[29] && !u2, l1}, "R4 R5 R6");
        if (u2) push(3, w3, {17'd0, w0[28] && !u1, w0[29], l2}, "R4 R5 R6");
        push(2, a, w0 & 32'h7fff_ffff, "R7");
        if (w0[30] && w0[29]) push(4, 0, 0, "R8");
        shadow[a[8:2]] = w0 & 32'h7fff_ffff;
        nxt = chain ? w3 : (w0[21] ? base : a + 16);
    endtask

    task automatic expect_walk(input logic [31:0] start, input bit chain, input logic [31:0] base,
                               input string first_tag);
        logic [31:0] a, nxt;
        bit owned;
        string tag;
        a = start;
        tag = first_tag;
        for (int i = 0; i < 8; i++) begin
            expect_desc(a, chain, base, tag, owned, nxt);
            if (!owned) break;
            tag = chain ? "R10" : "R9";
            a = nxt;
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        mem[a[8:2]] = w0; mem[a[8:2]+1] = w1; mem[a[8:2]+2] = w2; mem[a[8:2]+3] = w3;
        for (int k = 0; k < 4; k++) shadow[a[8:2]+k] = mem[a[8:2]+k];
    endtask

    task automatic poll();
        @(negedge clk); poll_demand = 1'b1;
        @(negedge clk); poll_demand = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while ((expq.size() != 0 || !buf_unavail) && n < 5000) begin
            @(negedge clk); n++;
        end
        repeat (6) @(negedge clk);
        check({tag, " queue drained"}, expq.size(), 0);
        check({tag, " buf_unavail"}, buf_unavail, 1);
        check({tag, " no request while parked"}, {mem_req, seg_valid}, 0);
    endtask

    // Memory responder, data mover and monitor in one negedge process
    int mwait = 0, swait = 0;
    bit pend = 0;
    logic [AW-1:0] pend_addr;
    always @(negedge clk) begin
        if (pend) begin
            check("R11 request held", {mem_req, mem_addr}, {1'b1, pend_addr});
        end
        if (tx_irq) begin
            vectors++;
            if (expq.size() == 0 || expq[0].kind != 4) begin
                fails++;
                $display("FAIL R8: unexpected irq, actual 1 expected 0");
            end else void'(expq.pop_front());
        end
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req && rst_n) begin
            if (mwait >= int'(mem_addr[3:2])) begin
                mwait = 0;
                mon(mem_we ? 2 : 1, mem_addr, mem_we ? mem_wdata : 32'd0);
                if (mem_we) mem[mem_addr[8:2]] = mem_wdata;
                mem_rdata = mem[mem_addr[8:2]];
                mem_ack = 1'b1;
            end else mwait++;
        end
        pend = mem_req && !mem_ack;
        pend_addr = mem_addr;
        if (seg_done) seg_done = 1'b0;
        else if (seg_valid) begin
            if (swait > int'(seg_len[1:0])) begin
                swait = 0;
                mon(3, seg_addr, {17'd0, seg_first, seg_last, seg_len});
                seg_done = 1'b1;
            end else swait++;
        end
    end

    task automatic mon(input int kind, input logic [31:0] a, input logic [31:0] d);
        exp_t e;
        vectors++;
        if (expq.size() == 0) begin
            fails++;
            $display("FAIL R2: unexpected event kind %0d actual %h expected none", kind, a);
            return;
        end
        e = expq.pop_front();
        if (e.kind != kind || e.a !== a || e.d !== d) begin
            fails++;
            $display("FAIL %s: actual kind %0d addr %h data %h expected kind %0d addr %h data %h",
                     e.tag, kind, a, d, e.kind, e.a, e.d);
        end
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin mem[i] = '0; shadow[i] = '0; end
        cfg_base = 32'h40;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and quiet until poll
        check("R1 reset outputs", {mem_req, seg_valid, tx_irq, buf_unavail}, 0);
        repeat (10) @(negedge clk);
        check("R1 quiet before poll", {mem_req, seg_valid, tx_irq, buf_unavail}, 0);

        // Ring of three: both buffers, buffer 2 only, buffer 1 only with end-of-ring
        put_desc(32'h40, 32'h9000_0000, {16'd200, 16'd100}, 32'h1000, 32'h2000);
        put_desc(32'h50, 32'hE000_0000, {16'd50, 16'd0},    32'h1100, 32'h2100);
        put_desc(32'h60, 32'hF020_0000, {16'd0, 16'd8},     32'h1200, 32'h2200);
        expect_walk(32'h40, 1'b0, 32'h40, "R1");
        poll();
        drain("R9 ring wrap to returned descriptor R3");

        // Re-arm the base descriptor: self-wrap, no interrupt request
        put_desc(32'h40, 32'hB020_0000, {16'd3, 16'd5}, 32'h1300, 32'h2300);
        expect_walk(32'h40, 1'b0, 32'h40, "R3");
        poll();
        drain("R3 re-poll same address");

        // Chained mode after a fresh reset
        @(negedge clk); rst_n = 1'b0;
        cfg_chain = 1'b1; cfg_base = 32'h100;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset outputs again", {mem_req, seg_valid, tx_irq, buf_unavail}, 0);
        put_desc(32'h100, 32'h9000_0000, {16'd77, 16'd60}, 32'h3000, 32'h180);
        put_desc(32'h180, 32'hE020_0000, {16'd9, 16'd12},  32'h3100, 32'h100);
        expect_walk(32'h100, 1'b1, 32'h100, "R1");
        poll();
        drain("R10 chain link");
        check("R7 memory word returned", mem[32'h180 >> 2], 32'h6020_0000);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule